// File: doc/BRIEF.md
# JTAG Debug Interrupt Request Unit

This block is a JTAG test access port that gives an external debugger one way to interrupt the on-chip CPU. Shifting a dedicated instruction code into the instruction register sets a sticky request flag. That flag drives a level-sensitive interrupt line into the CPU clock domain, and it stays set until software writes zero to it through a small synchronous write strobe. The debugger can also read the flag back over the scan chain, as a 32-bit data register. Every other instruction code routes the scan path through an eight-bit bypass register, which is zeroed at each capture.

The TAP controller is a 16-state machine stepped by TMS on the rising TCK edge:
- Test-Logic-Reset goes to Run-Test/Idle on TMS=0 and holds on TMS=1.
- Run-Test/Idle goes to Select-DR on TMS=1.
- Select-DR goes to Capture-DR on 0 and to Select-IR on 1.
- Select-IR goes to Capture-IR on 0 and back to Test-Logic-Reset on 1.
- On either side (DR or IR), Capture goes to Shift on 0 and to Exit1 on 1.
- Shift holds on 0 and goes to Exit1 on 1.
- Exit1 goes to Pause on 0 and to Update on 1.
- Pause holds on 0 and goes to Exit2 on 1.
- Exit2 returns to Shift on 0 and goes to Update on 1.
- Update goes to Select-DR on 1 and to Run-Test/Idle on 0.

The request flag lives in the CPU clock domain. The set event crosses from TCK as a toggle through a two-flop synchronizer. The Test-Logic-Reset condition is synchronized the same way.

Top module: `dbg_irq_tap`

## Requirements
- R1: A CPU read strobe sampled on a `clk` edge loads `rdata` on that edge. Bit 0 of `rdata` carries the request flag and bits 15..1 read as zero.
- R2: An Update-IR with instruction code 8'h60 sets the request flag. `irq` is high within four `clk` cycles after the TCK edge that leaves Update-IR. No other code sets it.
- R3: Once set, `irq` stays high on every cycle until the flag is cleared. It is a level, not a pulse.
- R4: A CPU write with `wdata[0]`=0 clears the flag on the next `clk` edge. A write with `wdata[0]`=1 leaves the flag unchanged.
- R5: When a synchronized set and a CPU clearing write land on the same `clk` edge, the flag ends up set.
- R6: In Test-Logic-Reset, reached by five TCK cycles with TMS high, the flag is cleared and the instruction register returns to the bypass code 8'hFF.
- R7: `trst_n` low clears the flag at once, without any clock, and selects the bypass instruction.
- R8: With code 8'h60 selected, the data register is 32 bits and is shifted out LSB first. Bit 0 holds the flag captured at Capture-DR and bits 31..1 are zero.
- R9: With code 8'hFF, or any code other than 8'h60, the data path is an eight-bit bypass register. It is zeroed at Capture-DR, so the first eight bits out are 0 and TDI reappears on TDO eight TCK cycles later.
- R10: TDO changes only on the falling TCK edge. `tdo_oe` is high only in Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Test mode select, sampled on rising TCK |
| tdi | input | 1 | Serial scan input |
| trst_n | input | 1 | Asynchronous test reset, active low; also resets the CPU-side flag logic |
| tdo | output | 1 | Serial scan output, updated on falling TCK |
| tdo_oe | output | 1 | Output enable for TDO, high in the shift states |
| clk | input | 1 | CPU clock |
| wr_en | input | 1 | CPU write strobe for the interrupt-source register |
| wdata | input | 16 | CPU write data; only bit 0 acts |
| rd_en | input | 1 | CPU read strobe |
| rdata | output | 16 | Registered read data, flag in bit 0 |
| irq | output | 1 | Level interrupt request to the CPU |

## Verification
The checker watches the CPU-domain flag on every `clk` cycle:
- it rises only after a synchronized set event;
- it falls only after a clearing write or a synchronized Test-Logic-Reset;
- a set beats a simultaneous clear;
- Test-Logic-Reset forces it low;
- read data mirrors it.

Only the directed scenarios can show the TAP-side behaviour:
- the instruction-to-interrupt path through the TAP walk;
- the 32-bit scan image;
- the eight-cycle bypass delay;
- the falling-edge timing of TDO;
- the exact-edge collision between a set and a clear.

// File: rtl/dbg_irq_pkg.sv
package dbg_irq_pkg;

    typedef enum logic [3:0] {
        TS_RESET,
        TS_IDLE,
        TS_DR_SEL,
        TS_DR_CAP,
        TS_DR_SHIFT,
        TS_DR_EXIT1,
        TS_DR_PAUSE,
        TS_DR_EXIT2,
        TS_DR_UPD,
        TS_IR_SEL,
        TS_IR_CAP,
        TS_IR_SHIFT,
        TS_IR_EXIT1,
        TS_IR_PAUSE,
        TS_IR_EXIT2,
        TS_IR_UPD
    } tap_state_e;

    localparam int IR_BITS   = 8;
    localparam int BYP_BITS  = 8;
    localparam int SRC_BITS  = 16;
    localparam int SCAN_BITS = 32;
    localparam int SYNC_LEN  = 2;

    localparam logic [IR_BITS-1:0] OPC_BYPASS  = '1;
    localparam logic [IR_BITS-1:0] OPC_IRQ     = 8'h60;
    localparam logic [IR_BITS-1:0] OPC_CAPTURE = 8'h01;

endpackage

// File: rtl/dbg_tap_fsm.sv
module dbg_tap_fsm
    import dbg_irq_pkg::*;
(
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    output logic in_reset,
    output logic dr_cap,
    output logic dr_shift,
    output logic ir_cap,
    output logic ir_shift,
    output logic ir_upd
);

    tap_state_e cur_q, nxt;

    // state register
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) cur_q <= TS_RESET;
        else         cur_q <= nxt;
    end

    // transitions
    always_comb begin
        nxt = cur_q;
        unique case (cur_q)
            TS_RESET:    nxt = tms ? TS_RESET    : TS_IDLE;
            TS_IDLE:     nxt = tms ? TS_DR_SEL   : TS_IDLE;
            TS_DR_SEL:   nxt = tms ? TS_IR_SEL   : TS_DR_CAP;
            TS_DR_CAP:   nxt = tms ? TS_DR_EXIT1 : TS_DR_SHIFT;
            TS_DR_SHIFT: nxt = tms ? TS_DR_EXIT1 : TS_DR_SHIFT;
            TS_DR_EXIT1: nxt = tms ? TS_DR_UPD   : TS_DR_PAUSE;
            TS_DR_PAUSE: nxt = tms ? TS_DR_EXIT2 : TS_DR_PAUSE;
            TS_DR_EXIT2: nxt = tms ? TS_DR_UPD   : TS_DR_SHIFT;
            TS_DR_UPD:   nxt = tms ? TS_DR_SEL   : TS_IDLE;
            TS_IR_SEL:   nxt = tms ? TS_RESET    : TS_IR_CAP;
            TS_IR_CAP:   nxt = tms ? TS_IR_EXIT1 : TS_IR_SHIFT;
            TS_IR_SHIFT: nxt = tms ? TS_IR_EXIT1 : TS_IR_SHIFT;
            TS_IR_EXIT1: nxt = tms ? TS_IR_UPD   : TS_IR_PAUSE;
            TS_IR_PAUSE: nxt = tms ? TS_IR_EXIT2 : TS_IR_PAUSE;
            TS_IR_EXIT2: nxt = tms ? TS_IR_UPD   : TS_IR_SHIFT;
            TS_IR_UPD:   nxt = tms ? TS_DR_SEL   : TS_IDLE;
        endcase
    end

    // state decodes
    always_comb begin
        in_reset = (cur_q == TS_RESET);
        dr_cap   = (cur_q == TS_DR_CAP);
        dr_shift = (cur_q == TS_DR_SHIFT);
        ir_cap   = (cur_q == TS_IR_CAP);
        ir_shift = (cur_q == TS_IR_SHIFT);
        ir_upd   = (cur_q == TS_IR_UPD);
    end

endmodule

// File: rtl/dbg_tap_regs.sv
module dbg_tap_regs
    import dbg_irq_pkg::*;
#(
    parameter int                 IR_W    = IR_BITS,
    parameter int                 BYP_W   = BYP_BITS,
    parameter int                 SRC_W   = SRC_BITS,
    parameter int                 SCAN_W  = SCAN_BITS,
    parameter logic [IR_W-1:0]    OP_IRQ  = OPC_IRQ,
    parameter logic [IR_W-1:0]    OP_BYP  = OPC_BYPASS,
    parameter logic [IR_W-1:0]    OP_CAPT = OPC_CAPTURE
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tdi,
    input  logic in_reset,
    input  logic dr_cap,
    input  logic dr_shift,
    input  logic ir_cap,
    input  logic ir_shift,
    input  logic ir_upd,
    input  logic flag_i,
    output logic set_tog,
    output logic tdo,
    output logic tdo_oe
);

    localparam int PAD_W = SCAN_W - 1;

    logic [IR_W-1:0]   ir_q, ir_sr;
    logic [BYP_W-1:0]  byp_sr;
    logic [SCAN_W-1:0] src_sr;
    logic              sel_irq;

    assign sel_irq = (ir_q == OP_IRQ);

    // instruction register and its shift stage
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_q    <= OP_BYP;
            ir_sr   <= OP_CAPT;
            set_tog <= 1'b0;
        end else begin
            if (ir_cap)        ir_sr <= OP_CAPT;
            else if (ir_shift) ir_sr <= {tdi, ir_sr[IR_W-1:1]};

            if (in_reset)    ir_q <= OP_BYP;
            else if (ir_upd) ir_q <= ir_sr;

            if (ir_upd && (ir_sr == OP_IRQ)) set_tog <= ~set_tog;
        end
    end

    // interrupt-source scan image: zero-padded above the flag
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                   src_sr <= '0;
        else if (dr_cap && sel_irq)    src_sr <= {{PAD_W{1'b0}}, flag_i};
        else if (dr_shift && sel_irq)  src_sr <= {tdi, src_sr[SCAN_W-1:1]};
    end

    // bypass stage: untouched by reset, zeroed at capture
    always_ff @(posedge tck) begin
        if (dr_cap && !sel_irq)        byp_sr <= '0;
        else if (dr_shift && !sel_irq) byp_sr <= {tdi, byp_sr[BYP_W-1:1]};
    end

    // output stage on the falling edge
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= ir_shift | dr_shift;
            if (ir_shift)      tdo <= ir_sr[0];
            else if (dr_shift) tdo <= sel_irq ? src_sr[0] : byp_sr[0];
        end
    end

endmodule

// File: rtl/dbg_irq_src.sv
module dbg_irq_src
    import dbg_irq_pkg::*;
#(
    parameter int SRC_W  = SRC_BITS,
    parameter int SYNC_N = SYNC_LEN
) (
    input  logic             clk,
    input  logic             trst_n,
    input  logic             tog_i,
    input  logic             tlr_i,
    input  logic             wr_en,
    input  logic [SRC_W-1:0] wdata,
    input  logic             rd_en,
    output logic [SRC_W-1:0] rdata,
    output logic             irq,
    output logic             set_seen,
    output logic             tlr_seen
);

    logic [SYNC_N-1:0] tog_sync, tlr_sync;
    logic              tog_last, flag_q, unused_hi;

    assign unused_hi = ^wdata[SRC_W-1:1];
    assign set_seen  = tog_sync[SYNC_N-1] ^ tog_last;
    assign tlr_seen  = tlr_sync[SYNC_N-1];
    assign irq       = flag_q;

    always_ff @(posedge clk or negedge trst_n) begin
        if (!trst_n) begin
            tog_sync <= '0;
            tog_last <= 1'b0;
            tlr_sync <= '1;
            flag_q   <= 1'b0;
            rdata    <= '0;
        end else begin
            tog_sync <= {tog_sync[SYNC_N-2:0], tog_i};
            tlr_sync <= {tlr_sync[SYNC_N-2:0], tlr_i};
            tog_last <= tog_sync[SYNC_N-1];
            if (tlr_seen)                 flag_q <= 1'b0;
            else if (set_seen)            flag_q <= 1'b1;
            else if (wr_en && !wdata[0])  flag_q <= 1'b0;
            if (rd_en) rdata <= {{(SRC_W-1){1'b0}}, flag_q};
        end
    end

endmodule

// File: rtl/dbg_irq_tap.sv
module dbg_irq_tap
    import dbg_irq_pkg::*;
#(
    parameter int SRC_W  = SRC_BITS,
    parameter int IR_W   = IR_BITS,
    parameter int BYP_W  = BYP_BITS,
    parameter int SCAN_W = SCAN_BITS,
    parameter int SYNC_N = SYNC_LEN
) (
    input  logic             tck,
    input  logic             tms,
    input  logic             tdi,
    input  logic             trst_n,
    output logic             tdo,
    output logic             tdo_oe,
    input  logic             clk,
    input  logic             wr_en,
    input  logic [SRC_W-1:0] wdata,
    input  logic             rd_en,
    output logic [SRC_W-1:0] rdata,
    output logic             irq
);

    logic in_reset, dr_cap, dr_shift, ir_cap, ir_shift, ir_upd;
    logic set_tog, cpu_set, cpu_tlr;

    dbg_tap_fsm u_fsm (
        .tck      (tck),
        .trst_n   (trst_n),
        .tms      (tms),
        .in_reset (in_reset),
        .dr_cap   (dr_cap),
        .dr_shift (dr_shift),
        .ir_cap   (ir_cap),
        .ir_shift (ir_shift),
        .ir_upd   (ir_upd)
    );

    dbg_tap_regs #(
        .IR_W   (IR_W),
        .BYP_W  (BYP_W),
        .SRC_W  (SRC_W),
        .SCAN_W (SCAN_W)
    ) u_regs (
        .tck      (tck),
        .trst_n   (trst_n),
        .tdi      (tdi),
        .in_reset (in_reset),
        .dr_cap   (dr_cap),
        .dr_shift (dr_shift),
        .ir_cap   (ir_cap),
        .ir_shift (ir_shift),
        .ir_upd   (ir_upd),
        .flag_i   (irq),
        .set_tog  (set_tog),
        .tdo      (tdo),
        .tdo_oe   (tdo_oe)
    );

    dbg_irq_src #(
        .SRC_W  (SRC_W),
        .SYNC_N (SYNC_N)
    ) u_src (
        .clk      (clk),
        .trst_n   (trst_n),
        .tog_i    (set_tog),
        .tlr_i    (in_reset),
        .wr_en    (wr_en),
        .wdata    (wdata),
        .rd_en    (rd_en),
        .rdata    (rdata),
        .irq      (irq),
        .set_seen (cpu_set),
        .tlr_seen (cpu_tlr)
    );

endmodule

// File: rtl/dbg_irq_tap_chk.sv
module dbg_irq_tap_chk #(
    parameter int SRC_W = 16
) (
    input logic             clk,
    input logic             trst_n,
    input logic             wr_en,
    input logic             wr_bit0,
    input logic             rd_en,
    input logic [SRC_W-1:0] rdata,
    input logic             irq,
    input logic             set_seen,
    input logic             tlr_seen
);

    // R1
    read_mirror_chk: assert property (@(posedge clk) disable iff (!trst_n)
        rd_en |=> (rdata[0] == $past(irq)) && (rdata[SRC_W-1:1] == '0));

    // R2
    rise_needs_set_chk: assert property (@(posedge clk) disable iff (!trst_n)
        $rose(irq) |-> $past(set_seen));

    // R4
    fall_needs_clear_chk: assert property (@(posedge clk) disable iff (!trst_n)
        $fell(irq) |-> ($past(wr_en && !wr_bit0) || $past(tlr_seen)));

    // R5
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!trst_n)
        (set_seen && wr_en && !wr_bit0 && !tlr_seen) |=> irq);

    // R6
    tlr_clears_chk: assert property (@(posedge clk) disable iff (!trst_n)
        tlr_seen |=> !irq);

endmodule

bind dbg_irq_tap dbg_irq_tap_chk #(.SRC_W(SRC_W)) u_chk (
    .clk      (clk),
    .trst_n   (trst_n),
    .wr_en    (wr_en),
    .wr_bit0  (wdata[0]),
    .rd_en    (rd_en),
    .rdata    (rdata),
    .irq      (irq),
    .set_seen (cpu_set),
    .tlr_seen (cpu_tlr)
);

// File: tb/dbg_irq_tap_tb_top.sv
`timescale 1ns/1ps
module dbg_irq_tap_tb_top;

    logic        clk = 1'b0;
    logic        tck = 1'b0, tms = 1'b1, tdi = 1'b0, trst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [15:0] wdata = '0;
    logic        tdo, tdo_oe, irq;
    logic [15:0] rdata;
    int          total = 0, bad = 0;

    always #2 clk = ~clk;

    dbg_irq_tap dut_i (
        .tck(tck), .tms(tms), .tdi(tdi), .trst_n(trst_n),
        .tdo(tdo), .tdo_oe(tdo_oe), .clk(clk), .wr_en(wr_en),
        .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic m, input logic d, output logic so, output logic soe, output logic smid);
        tms = m; tdi = d;
        @(negedge clk);
        so = tdo; soe = tdo_oe;
        tck = 1'b1;
        @(negedge clk);
        smid = tdo;
        tck = 1'b0;
        @(negedge clk);
    endtask

    task automatic step(input logic m);
        logic a, b, c;
        pulse(m, 1'b0, a, b, c);
    endtask

    task automatic cpu_write(input logic [15:0] v);
        @(negedge clk); wr_en = 1'b1; wdata = v;
        @(negedge clk); wr_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic cpu_read(output logic [15:0] v);
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        v = rdata;
    endtask

    // from Run-Test/Idle through a DR scan of n bits back to Run-Test/Idle
    task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout,
                           output bit oe_ok, output bit mid_ok);
        logic so, soe, smid;
        dout = '0; oe_ok = 1; mid_ok = 1;
        step(1'b1); step(1'b0); step(1'b0);
        for (int i = 0; i < n; i++) begin
            pulse(i == n - 1, din[i], so, soe, smid);
            dout[i] = so;
            if (!soe) oe_ok = 0;
            if (smid !== so) mid_ok = 0;
        end
        step(1'b1); step(1'b0);
    endtask

    // load an instruction; collide=1 puts a CPU clear on the set edge
    task automatic load_ir(input logic [7:0] code, input bit collide);
        logic so, soe, smid;
        step(1'b1); step(1'b1); step(1'b0); step(1'b0);
        for (int i = 0; i < 8; i++) pulse(i == 7, code[i], so, soe, smid);
        step(1'b1);
        if (!collide) begin
            step(1'b0);
        end else begin
            tms = 1'b0;
            @(negedge clk); tck = 1'b1;
            @(posedge clk);
            @(posedge clk);
            @(negedge clk); wr_en = 1'b1; wdata = 16'h0000;
            @(posedge clk);
            @(negedge clk); wr_en = 1'b0; tck = 1'b0;
        end
    endtask

    task automatic bypass_check(input string tag);
        logic [31:0] dout;
        bit oe_ok, mid_ok;
        scan_dr(16, 32'h0000_A5C3, dout, oe_ok, mid_ok);
        chk(dout[15:0] == 16'hC300, tag, dout[15:0], 16'hC300);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        repeat (3) @(negedge clk);
        // R7: trst held low
        chk(irq == 1'b0, "R7 irq in reset", irq, 0);
        // R10: no drive outside shift
        chk(tdo_oe == 1'b0, "R10 oe in reset", tdo_oe, 0);
        trst_n = 1'b1;
        step(1'b0);
        cpu_read(v);
        // R1: reset read
        chk(v == 16'h0000, "R1 reset read", v, 0);
    endtask

    task automatic t_bypass;
        logic [31:0] dout;
        bit oe_ok, mid_ok;
        scan_dr(16, 32'h0000_A5C3, dout, oe_ok, mid_ok);
        // R9: eight zeros, then TDI delayed by eight
        chk(dout[15:0] == 16'hC300, "R9 bypass delay", dout[15:0], 16'hC300);
        // R10: enable during shift, change on falling edge only
        chk(oe_ok, "R10 oe in shift", oe_ok, 1);
        chk(mid_ok, "R10 tdo held over rising edge", mid_ok, 1);
        @(negedge clk);
        chk(tdo_oe == 1'b0, "R10 oe idle", tdo_oe, 0);
    endtask

    task automatic t_set;
        logic [15:0] v;
        load_ir(8'h60, 0);
        repeat (4) @(negedge clk);
        // R2
        chk(irq == 1'b1, "R2 irq after load", irq, 1);
        repeat (40) @(negedge clk);
        // R3
        chk(irq == 1'b1, "R3 irq level held", irq, 1);
        cpu_read(v);
        // R1
        chk(v == 16'h0001, "R1 read flag", v, 1);
    endtask

    task automatic t_scan(input logic exp_flag);
        logic [31:0] dout;
        bit oe_ok, mid_ok;
        scan_dr(32, 32'h0, dout, oe_ok, mid_ok);
        // R8
        chk(dout == {31'b0, exp_flag}, "R8 scan image", dout, {31'b0, exp_flag});
    endtask

    task automatic t_clear;
        logic [15:0] v;
        cpu_write(16'hFFFF);
        // R4: write of one keeps the flag
        chk(irq == 1'b1, "R4 write one ignored", irq, 1);
        cpu_write(16'hFFFE);
        // R4: write of zero clears
        chk(irq == 1'b0, "R4 write zero clears", irq, 0);
        cpu_read(v);
        chk(v == 16'h0000, "R4 read after clear", v, 0);
        t_scan(1'b0);
    endtask

    task automatic t_collide;
        load_ir(8'h60, 1);
        // R5
        chk(irq == 1'b1, "R5 set beats clear", irq, 1);
    endtask

    task automatic t_tlr;
        for (int i = 0; i < 5; i++) step(1'b1);
        repeat (4) @(negedge clk);
        // R6
        chk(irq == 1'b0, "R6 flag cleared in reset state", irq, 0);
        step(1'b0);
        bypass_check("R6 bypass after reset state");
    endtask

    task automatic t_trst;
        load_ir(8'h60, 0);
        repeat (4) @(negedge clk);
        chk(irq == 1'b1, "R2 irq set again", irq, 1);
        @(negedge clk); #0.5 trst_n = 1'b0;
        #0.5;
        // R7: asynchronous clear
        chk(irq == 1'b0, "R7 trst clears at once", irq, 0);
        repeat (3) @(negedge clk);
        trst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(irq == 1'b0, "R7 stays clear", irq, 0);
        step(1'b0);
        bypass_check("R7 bypass after trst");
    endtask

    task automatic t_other;
        load_ir(8'h12, 0);
        repeat (6) @(negedge clk);
        // R2: other codes do not set
        chk(irq == 1'b0, "R2 other code no set", irq, 0);
        bypass_check("R9 unknown code uses bypass");
    endtask

    initial begin
        t_reset();
        t_bypass();
        t_set();
        t_scan(1'b1);
        t_clear();
        t_collide();
        t_scan(1'b1);
        t_tlr();
        t_trst();
        t_other();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule